// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block watches the six destination-address bytes at the head of each received Ethernet frame and decides whether the frame is kept. The address is tested against a programmable station address, against the all-ones broadcast pattern, and against a 64-bit hash table. The table is indexed by six bits of the CRC-32 of the address. Five enables (station, broadcast, multicast, hash, promiscuous) select which classes are accepted.

Together with the accept decision, the block produces a 16-bit receive-status word that describes how the frame was classified. It also reports the 6-bit hash index of every address. The CRC-32 runs over the address one byte per clock, so the result is available one cycle after the sixth byte. Frame length and CRC verdict for the whole frame come from upstream logic and are sampled with the sixth byte.

Top module: `dest_addr_filter`

## Requirements
- R1: A byte with `da_valid` and `da_sof` high is address byte 0. The following `da_valid` cycles carry bytes 1..5, and idle cycles may fall between them. A new `da_sof` restarts the address. `res_valid` pulses for exactly one cycle, in the cycle after byte 5, and is low otherwise.
- R2: `cfg_ia[47:40]` is compared with byte 0 and `cfg_ia[7:0]` with byte 5. A full match sets status bit 10 (0x0400). With `cfg_en[0]` (station) or `cfg_en[4]` (promiscuous) set, the frame is accepted at once and hash results are not applied.
- R3: An address of six 0xFF bytes is broadcast and sets status bit 11 (0x0800). It is accepted only when `cfg_en[1]` or `cfg_en[4]` is set. It is never hashed, so status bits 6 and 9 stay clear.
- R4: `res_hash_idx` is bits 31..26 of the bitwise-inverted CRC-32 of the six bytes. The CRC uses the reflected polynomial 0xEDB88320, starts from 0xFFFFFFFF, and shifts each byte in least significant bit first.
- R5: A table write with `tbl_we` high replaces table bits 8n..8n+7 with `tbl_data`, where n = `tbl_sel`, and leaves all other bits unchanged. Hash index i selects table bit i.
- R6: When the table bit is set and bit 7 of byte 0 is 1, the frame is multicast. This sets status bit 9 (0x0200) and leaves the hashed flag clear. The frame is accepted when `cfg_en[2]` or `cfg_en[4]` is set.
- R7: When the table bit is set and the frame is not multicast, the hashed flag sets status bit 6 (0x0040). The frame is accepted when `cfg_en[3]` or `cfg_en[4]` is set.
- R8: An address that matches no accepted class is accepted only when `cfg_en[4]` is set.
- R9: The status word always has bit 2 set. Bit 8 is set when the frame is OK, meaning `frm_crc_good` is high and 64 <= `frm_len` <= 1518.
- R10: When the frame is hashed and OK, status bits 14..9 carry the hash index. Otherwise the word holds bit 10 (station), bit 11 (broadcast), bit 12 (`frm_crc_err`), bit 13 (length below 64) and bit 14 (length above 1518).
- R11: The enables and station address present in the cycle of byte 0 apply to the whole address. So do the table contents from writes completed before that cycle. Later changes apply from the next frame.
- R12: After reset, `res_valid`, `res_accept`, `res_status` and `res_hash_idx` are zero and the hash table is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| da_valid | input | 1 | Address byte present |
| da_sof | input | 1 | Marks address byte 0 |
| da_byte | input | 8 | Address byte |
| frm_len | input | 11 | Frame length in bytes, sampled with byte 5 |
| frm_crc_good | input | 1 | Frame CRC good, sampled with byte 5 |
| frm_crc_err | input | 1 | Frame CRC error, sampled with byte 5 |
| cfg_en | input | 5 | Enables: 0 station, 1 broadcast, 2 multicast, 3 hash, 4 promiscuous |
| cfg_ia | input | 48 | Station address, byte 0 in bits 47:40 |
| tbl_we | input | 1 | Hash table byte write |
| tbl_sel | input | 3 | Hash table byte number |
| tbl_data | input | 8 | Hash table byte value |
| res_valid | output | 1 | Result pulse |
| res_accept | output | 1 | Frame accepted |
| res_status | output | 16 | Receive-status word |
| res_hash_idx | output | 6 | Hash index of the address |

## Verification
The assertions assume that upstream logic presents address bytes only in the frame-start pattern of R1. Metadata is assumed to be meaningful only in the cycle of byte 5, and reset is assumed to hold `da_valid` low. They check the status word only in the cycle of `res_valid`, where the layout rule of R10 decides how the upper bits are read. The stimulus drives bytes and configuration on the falling clock edge and keeps `da_valid` low outside frames. It changes configuration only between frames, except in the one test aimed at R11.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;
  localparam int STATUS_W = 16;

  localparam int ST_BASE   = 2;
  localparam int ST_HASHED = 6;
  localparam int ST_OK     = 8;
  localparam int ST_MCAST  = 9;
  localparam int ST_IA     = 10;
  localparam int ST_BCAST  = 11;
  localparam int ST_CRCERR = 12;
  localparam int ST_RUNT   = 13;
  localparam int ST_LONG   = 14;
  localparam int ST_IDX_LO = 9;

  typedef struct packed {
    logic prom;
    logic hash;
    logic mcast;
    logic bcast;
    logic ia;
  } accept_en_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/dafilt_crc.sv
module dafilt_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step_en,
  input  logic        restart,
  input  logic [7:0]  data,
  output logic [31:0] crc_nxt
);
  import dafilt_pkg::*;

  logic [31:0] crc_q;

  always_comb begin
    crc_nxt = crc_step(restart ? CRC_INIT : crc_q, data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_INIT;
    else if (step_en) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/dafilt_hash_table.sv
module dafilt_hash_table #(
  parameter int TBL_BITS = 64,
  localparam int TBL_BYTES = TBL_BITS / 8,
  localparam int SEL_W = $clog2(TBL_BYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [7:0]          wr_data,
  output logic [TBL_BITS-1:0] table_q
);
  for (genvar g = 0; g < TBL_BYTES; g++) begin : g_byte
    logic hit;
    assign hit = wr_en && (wr_sel == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) table_q[8*g +: 8] <= 8'h00;
      else if (hit) table_q[8*g +: 8] <= wr_data;
    end
  end
endmodule

// File: rtl/dafilt_classify.sv
module dafilt_classify #(
  parameter int HASH_BITS = 6,
  parameter int LEN_W = 11,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518,
  localparam int TBL_BITS = 2 ** HASH_BITS
) (
  input  dafilt_pkg::accept_en_t           en,
  input  logic                             ia_hit,
  input  logic                             bc_hit,
  input  logic                             grp_bit,
  input  logic [HASH_BITS-1:0]             hash_idx,
  input  logic [TBL_BITS-1:0]              table_bits,
  input  logic [LEN_W-1:0]                 len,
  input  logic                             crc_good,
  input  logic                             crc_err,
  output logic                             accept,
  output logic [dafilt_pkg::STATUS_W-1:0]  status
);
  import dafilt_pkg::*;

  logic hbit, mc, hashed, ok, runt, long_f;

  assign hbit   = table_bits[hash_idx];
  assign runt   = len < LEN_W'(MIN_LEN);
  assign long_f = len > LEN_W'(MAX_LEN);
  assign ok     = crc_good && !runt && !long_f;

  always_comb begin
    accept = 1'b0;
    mc     = 1'b0;
    hashed = 1'b0;
    if (ia_hit && (en.ia || en.prom)) begin
      accept = 1'b1;
    end else if (bc_hit) begin
      accept = en.bcast || en.prom;
    end else if (hbit) begin
      if (grp_bit) begin
        mc     = 1'b1;
        accept = en.mcast || en.prom;
      end else begin
        hashed = 1'b1;
        accept = en.hash || en.prom;
      end
    end else begin
      accept = en.prom;
    end
  end

  always_comb begin
    status            = '0;
    status[ST_BASE]   = 1'b1;
    status[ST_OK]     = ok;
    status[ST_MCAST]  = mc;
    status[ST_HASHED] = hashed;
    if (hashed && ok) begin
      status[ST_IDX_LO +: HASH_BITS] = hash_idx;
    end else begin
      status[ST_IA]     = ia_hit;
      status[ST_BCAST]  = bc_hit;
      status[ST_CRCERR] = crc_err;
      status[ST_RUNT]   = runt;
      status[ST_LONG]   = long_f;
    end
  end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS = 6,
  parameter int LEN_W = 11,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518,
  localparam int TBL_BITS = 2 ** HASH_BITS,
  localparam int SEL_W = $clog2(TBL_BITS / 8),
  localparam int CNT_W = $clog2(ADDR_BYTES),
  localparam int IA_W = 8 * ADDR_BYTES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  da_valid,
  input  logic                  da_sof,
  input  logic [7:0]            da_byte,
  input  logic [LEN_W-1:0]      frm_len,
  input  logic                  frm_crc_good,
  input  logic                  frm_crc_err,
  input  logic [4:0]            cfg_en,
  input  logic [IA_W-1:0]       cfg_ia,
  input  logic                  tbl_we,
  input  logic [SEL_W-1:0]      tbl_sel,
  input  logic [7:0]            tbl_data,
  output logic                  res_valid,
  output logic                  res_accept,
  output logic [15:0]           res_status,
  output logic [HASH_BITS-1:0]  res_hash_idx
);
  import dafilt_pkg::*;

  logic [CNT_W-1:0]    cnt_q, cnt_d, pos;
  logic                ia_q, ia_d, bc_q, bc_d, grp_q, grp_d;
  accept_en_t          en_q, en_d;
  logic [IA_W-1:0]     sta_q, sta_d, sta_src;
  logic [TBL_BITS-1:0] tbl_live, tbl_q, tbl_d;
  logic                first, cont, take, last;
  logic [7:0]          ia_byte;
  logic [31:0]         crc_nxt, crc_inv;
  logic [HASH_BITS-1:0] idx;
  logic                acc_c;
  logic [STATUS_W-1:0] st_c;
  logic                vld_d, acc_d;
  logic [STATUS_W-1:0] st_d;
  logic [HASH_BITS-1:0] idx_d;

  assign first = da_valid && da_sof;
  assign cont  = da_valid && !da_sof && (cnt_q != '0);
  assign take  = first || cont;
  assign pos   = first ? '0 : cnt_q;
  assign last  = take && (pos == CNT_W'(ADDR_BYTES - 1));

  dafilt_crc u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (take),
    .restart (first),
    .data    (da_byte),
    .crc_nxt (crc_nxt)
  );

  assign crc_inv = ~crc_nxt;
  assign idx     = crc_inv[31 -: HASH_BITS];

  dafilt_hash_table #(.TBL_BITS(TBL_BITS)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_we),
    .wr_sel  (tbl_sel),
    .wr_data (tbl_data),
    .table_q (tbl_live)
  );

  dafilt_classify #(
    .HASH_BITS (HASH_BITS),
    .LEN_W     (LEN_W),
    .MIN_LEN   (MIN_LEN),
    .MAX_LEN   (MAX_LEN)
  ) u_cls (
    .en         (en_q),
    .ia_hit     (ia_d),
    .bc_hit     (bc_d),
    .grp_bit    (grp_q),
    .hash_idx   (idx),
    .table_bits (tbl_q),
    .len        (frm_len),
    .crc_good   (frm_crc_good),
    .crc_err    (frm_crc_err),
    .accept     (acc_c),
    .status     (st_c)
  );

  // Byte tracking and per-frame configuration capture
  always_comb begin
    sta_src = first ? cfg_ia : sta_q;
    ia_byte = sta_src[8*(ADDR_BYTES - 1 - int'(pos)) +: 8];
    cnt_d   = cnt_q;
    ia_d    = ia_q;
    bc_d    = bc_q;
    grp_d   = grp_q;
    en_d    = en_q;
    sta_d   = sta_q;
    tbl_d   = tbl_q;
    if (take) begin
      ia_d  = (first || ia_q) && (da_byte == ia_byte);
      bc_d  = (first || bc_q) && (da_byte == 8'hFF);
      cnt_d = last ? '0 : pos + CNT_W'(1);
    end
    if (first) begin
      grp_d = da_byte[7];
      en_d  = accept_en_t'(cfg_en);
      sta_d = cfg_ia;
      tbl_d = tbl_live;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ia_q  <= 1'b0;
      bc_q  <= 1'b0;
      grp_q <= 1'b0;
      en_q  <= '0;
      sta_q <= '0;
      tbl_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      ia_q  <= ia_d;
      bc_q  <= bc_d;
      grp_q <= grp_d;
      en_q  <= en_d;
      sta_q <= sta_d;
      tbl_q <= tbl_d;
    end
  end

  // Result register
  always_comb begin
    vld_d = last;
    acc_d = res_accept;
    st_d  = res_status;
    idx_d = res_hash_idx;
    if (last) begin
      acc_d = acc_c;
      st_d  = st_c;
      idx_d = idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_accept   <= 1'b0;
      res_status   <= '0;
      res_hash_idx <= '0;
    end else begin
      res_valid    <= vld_d;
      res_accept   <= acc_d;
      res_status   <= st_d;
      res_hash_idx <= idx_d;
    end
  end
endmodule

// File: rtl/dafilt_chk.sv
module dafilt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        da_valid,
  input logic        res_valid,
  input logic [15:0] res_status,
  input logic [5:0]  res_hash_idx
);
  logic hash_layout;
  assign hash_layout = res_status[6] && res_status[8];

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R1

  AST_RESULT_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(da_valid)); // R1

  AST_BASE_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_status[2]); // R9

  AST_BCAST_UNHASHED: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !hash_layout && res_status[11]) |-> (!res_status[6] && !res_status[9])); // R3

  AST_MCAST_UNHASHED: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !hash_layout) |-> !(res_status[6] && res_status[9])); // R6

  AST_IDX_IN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && hash_layout) |-> (res_status[14:9] == res_hash_idx)); // R10

  AST_LEN_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !hash_layout) |-> !(res_status[13] && res_status[14])); // R10
endmodule

bind dest_addr_filter dafilt_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .da_valid     (da_valid),
  .res_valid    (res_valid),
  .res_status   (res_status),
  .res_hash_idx (res_hash_idx)
);

// File: tb/test_dest_addr_filter.sv
module test_dest_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        da_valid = 1'b0, da_sof = 1'b0;
  logic [7:0]  da_byte = '0;
  logic [10:0] frm_len = '0;
  logic        frm_crc_good = 1'b0, frm_crc_err = 1'b0;
  logic [4:0]  cfg_en = '0;
  logic [47:0] cfg_ia = '0;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_sel = '0;
  logic [7:0]  tbl_data = '0;
  logic        res_valid, res_accept;
  logic [15:0] res_status;
  logic [5:0]  res_hash_idx;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [63:0] tbl_m = '0;
  bit mid_apply = 0;
  logic [4:0]  mid_en = '0;
  logic [47:0] mid_ia = '0;

  always #5 clk = ~clk;

  dest_addr_filter i_dest_addr_filter (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_sof(da_sof), .da_byte(da_byte),
    .frm_len(frm_len), .frm_crc_good(frm_crc_good), .frm_crc_err(frm_crc_err),
    .cfg_en(cfg_en), .cfg_ia(cfg_ia), .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_data(tbl_data),
    .res_valid(res_valid), .res_accept(res_accept), .res_status(res_status),
    .res_hash_idx(res_hash_idx)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_idx(input logic [47:0] da);
    logic [31:0] c;
    logic [31:0] inv;
    c = 32'hFFFFFFFF;
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < 8; j++) begin
        if (c[0] ^ da[47 - 8*k - 7 + j]) c = (c >> 1) ^ 32'hEDB88320;
        else c = c >> 1;
      end
    end
    inv = ~c;
    return inv[31:26];
  endfunction

  // Behavioural model of the filter decision (R2..R10)
  task automatic ref_eval(input logic [47:0] da, input logic [4:0] en, input logic [47:0] ia,
                          input logic [63:0] tbl, input int len, input bit good, input bit bad,
                          output bit acc, output logic [15:0] st, output logic [5:0] idx);
    bit ind, bc, mc, hs, ok;
    idx = ref_idx(da);
    ind = (da == ia);
    bc  = (da == 48'hFFFF_FFFF_FFFF);
    mc = 0; hs = 0;
    ok = good && len >= 64 && len <= 1518;
    if (ind && (en[0] || en[4])) acc = 1;
    else if (bc) acc = en[1] || en[4];
    else if (tbl[idx] && da[47]) begin mc = 1; acc = en[2] || en[4]; end
    else if (tbl[idx]) begin hs = 1; acc = en[3] || en[4]; end
    else acc = en[4];
    st = 16'h0004;
    if (ok) st = st | 16'h0100;
    if (mc) st = st | 16'h0200;
    if (hs) st = st | 16'h0040;
    if (hs && ok) st = st | (16'(idx) << 9);
    else begin
      if (ind) st = st | 16'h0400;
      if (bc) st = st | 16'h0800;
      if (bad) st = st | 16'h1000;
      if (len < 64) st = st | 16'h2000;
      if (len > 1518) st = st | 16'h4000;
    end
  endtask

  task automatic wr_tbl(input int n, input logic [7:0] v);
    @(negedge clk);
    tbl_we = 1; tbl_sel = 3'(n); tbl_data = v;
    @(negedge clk);
    tbl_we = 0;
    tbl_m[8*n +: 8] = v;
  endtask

  task automatic set_hash_bit(input logic [47:0] da);
    int i;
    logic [7:0] b;
    i = int'(ref_idx(da));
    b = tbl_m[8*(i/8) +: 8];
    b[i%8] = 1'b1;
    wr_tbl(i/8, b);
  endtask

  task automatic send(input logic [47:0] da, input int len, input bit good, input bit bad,
                      input int gap, input string req);
    bit acc;
    logic [15:0] st;
    logic [5:0] idx;
    ref_eval(da, cfg_en, cfg_ia, tbl_m, len, good, bad, acc, st, idx);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k > 0) check("R1", "res_valid during address", 32'(res_valid), 0);
      da_valid = 1; da_sof = (k == 0); da_byte = da[47 - 8*k -: 8];
      if (k == 5) begin frm_len = 11'(len); frm_crc_good = good; frm_crc_err = bad; end
      if (k == 2 && mid_apply) begin cfg_en = mid_en; cfg_ia = mid_ia; end
      if (k < 5) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          da_valid = 0; da_sof = 0;
        end
      end
    end
    @(negedge clk);
    da_valid = 0; da_sof = 0;
    check("R1", "res_valid pulse", 32'(res_valid), 1);
    check(req, "accept", 32'(res_accept), 32'(acc));
    check(req, "status", 32'(res_status), 32'(st));
    check("R4", "hash index", 32'(res_hash_idx), 32'(idx));
    @(negedge clk);
    check("R1", "res_valid drops", 32'(res_valid), 0);
  endtask

  localparam logic [47:0] IA  = 48'h02_11_22_33_44_55;
  localparam logic [47:0] BC  = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MC  = 48'h81_00_5E_00_00_FB;
  localparam logic [47:0] UC  = 48'h00_A0_C9_14_C8_29;
  localparam logic [47:0] UC2 = 48'h00_1B_21_3A_9F_10;

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12", "res_valid reset", 32'(res_valid), 0);
    check("R12", "accept reset", 32'(res_accept), 0);
    check("R12", "status reset", 32'(res_status), 0);
    check("R12", "index reset", 32'(res_hash_idx), 0);
    rst_n = 1;
    cfg_ia = IA;
    // R12: empty table after reset -> unicast unhashed, hash-only enable rejects
    cfg_en = 5'b01000;
    send(UC, 100, 1, 0, 0, "R12");
    // R2 station match
    cfg_en = 5'b00001;
    send(IA, 100, 1, 0, 0, "R2");
    cfg_en = 5'b00000;
    send(IA, 100, 1, 0, 0, "R2");
    // R3 broadcast
    cfg_en = 5'b00010;
    send(BC, 64, 1, 0, 0, "R3");
    cfg_en = 5'b00001;
    send(BC, 64, 1, 0, 0, "R3");
    set_hash_bit(BC);
    cfg_en = 5'b01100;
    send(BC, 64, 1, 0, 0, "R3");
    // R6 multicast
    set_hash_bit(MC);
    cfg_en = 5'b00100;
    send(MC, 200, 1, 0, 0, "R6");
    cfg_en = 5'b01000;
    send(MC, 200, 1, 0, 0, "R6");
    // R7 hashed unicast, R10 hash layout and regular layout
    set_hash_bit(UC);
    cfg_en = 5'b01000;
    send(UC, 300, 1, 0, 0, "R7");
    send(UC, 300, 0, 1, 0, "R10");
    send(UC, 40, 1, 0, 0, "R10");
    send(UC, 1600, 1, 0, 0, "R10");
    send(UC, 1518, 1, 0, 0, "R9");
    // R8 no match
    cfg_en = 5'b10000;
    send(UC2, 64, 1, 0, 0, "R8");
    cfg_en = 5'b01111;
    send(UC2, 63, 1, 0, 0, "R8");
    // R5 byte replacement: all ones, then clear the byte holding UC2's bit
    for (int n = 0; n < 8; n++) wr_tbl(n, 8'hFF);
    cfg_en = 5'b01000;
    send(UC2, 64, 1, 0, 0, "R5");
    wr_tbl(int'(ref_idx(UC2)) / 8, 8'h00);
    send(UC2, 64, 1, 0, 0, "R5");
    send(UC, 64, 1, 0, 0, "R5");
    // R1 idle gaps between bytes
    cfg_en = 5'b00001;
    send(IA, 80, 1, 0, 2, "R1");
    // R1 restart by a new start-of-frame mid-address
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      da_valid = 1; da_sof = (k == 0); da_byte = 8'h5A;
    end
    send(IA, 80, 1, 0, 0, "R1");
    // R11 configuration change mid-address applies to the next frame only
    cfg_en = 5'b00001;
    mid_apply = 1; mid_en = 5'b00000; mid_ia = 48'h02_99_99_99_99_99;
    send(IA, 90, 1, 0, 0, "R11");
    mid_apply = 0;
    send(IA, 90, 1, 0, 0, "R11");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule